// File: doc/BRIEF.md
# Circular Hardware Return Stack

This block keeps return addresses for a small microcontroller core. The core strobes a push when it executes a subroutine call or when an interrupt vectors. It strobes a pop when it executes any of its three return-type instructions. The top-of-stack output then gives the address at which execution resumes. The stack sits outside program and data memory. Its pointer is internal, and software cannot read or write it.

The stack holds eight 13-bit entries and is circular. Pushing past eight entries overwrites the oldest ones without any report. Popping past empty wraps the same way and returns whatever an entry held before. No overflow or underflow flag exists.

Top module: `circ_ret_stack`

## Requirements
- R1: While and after synchronous reset `rst` is high, the internal pointer is zero and `tos` reads 0 until the first push or pop.
- R2: One cycle after a push alone, `tos` equals the `push_addr` value that was presented with that push.
- R3: One cycle after a pop alone, `tos` shows the entry that was pushed just before the popped one (last in, first out).
- R4: Eight pushes followed by eight pops return the eight addresses in reverse order.
- R5: The pointer wraps modulo 8 on push. The ninth push overwrites the entry of the first push, and the tenth overwrites the entry of the second.
- R6: The pointer wraps modulo 8 on pop. Popping beyond the live entries returns the stale contents of the wrapped slot and gives no error.
- R7: When push and pop are both high in the same cycle, the pop applies first and the push second. The top entry is replaced by `push_addr`, the pointer is unchanged, and the entries below are untouched.
- R8: In a cycle with neither strobe, `tos` and the stored entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Push strobe (call or interrupt vector) |
| pop | input | 1 | Pop strobe (return-type instruction) |
| push_addr | input | 13 | Return address to store on push |
| tos | output | 13 | Registered top-of-stack address |

## Verification
The assertions treat `push` and `pop` as single-cycle strobes sampled only at rising edges. They accept either strobe alone or both together as legal, and they treat `push_addr` as meaningful only when `push` is high. The bench drives every strobe and data change on the falling edge and holds each operation for exactly one cycle, so each edge sees one clean operation. The stale-data pop check runs only after every slot has been written once. Each value the check expects is therefore a value the bench itself put there, not the uninitialised contents of storage.

// File: rtl/circ_ret_stack_pkg.sv
package circ_ret_stack_pkg;
  localparam int unsigned DEPTH  = 8;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned PTR_W  = $clog2(DEPTH);

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_SWAP = 2'b11
  } stk_op_e;
endpackage

// File: rtl/crs_pointer.sv
module crs_pointer
  import circ_ret_stack_pkg::*;
#(
  parameter int unsigned P_W = PTR_W
) (
  input  logic           clk,
  input  logic           rst,
  input  stk_op_e        op,
  output logic [P_W-1:0] ptr
);
  localparam logic [P_W-1:0] ONE = {{(P_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else begin
      unique case (op)
        OP_PUSH: ptr <= ptr + ONE;
        OP_POP:  ptr <= ptr - ONE;
        default: ptr <= ptr;
      endcase
    end
  end

  AST_PTR_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    op == OP_PUSH |=> ptr == P_W'($past(ptr) + ONE)); // R5
  AST_PTR_WRAP_DN: assert property (@(posedge clk) disable iff (rst)
    op == OP_POP |=> ptr == P_W'($past(ptr) - ONE)); // R6
  AST_PTR_SWAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    op == OP_SWAP |=> $stable(ptr)); // R7
endmodule

// File: rtl/crs_store.sv
module crs_store
  import circ_ret_stack_pkg::*;
#(
  parameter int unsigned N   = DEPTH,
  parameter int unsigned W   = ADDR_W,
  parameter int unsigned A_W = PTR_W
) (
  input  logic           clk,
  input  logic           we,
  input  logic [A_W-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic [A_W-1:0] raddr,
  output logic [W-1:0]   rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/circ_ret_stack.sv
module circ_ret_stack
  import circ_ret_stack_pkg::*;
#(
  parameter int unsigned STK_DEPTH = DEPTH,
  parameter int unsigned STK_W     = ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [STK_W-1:0] push_addr,
  output logic [STK_W-1:0] tos
);
  localparam int unsigned     P_W = $clog2(STK_DEPTH);
  localparam logic [P_W-1:0]  ONE = {{(P_W-1){1'b0}}, 1'b1};
  localparam logic [P_W-1:0]  TWO = P_W'(2);

  stk_op_e        op;
  logic [P_W-1:0] ptr;
  logic [P_W-1:0] waddr;
  logic [P_W-1:0] raddr;
  logic [STK_W-1:0] rdata;
  logic           we;

  assign op    = stk_op_e'({push, pop});
  assign we    = push;
  // A swap overwrites the current top; a plain push fills the free slot.
  assign waddr = pop ? (ptr - ONE) : ptr;
  // After a plain pop the new top sits two below the current pointer.
  assign raddr = ptr - TWO;

  crs_pointer #(.P_W(P_W)) u_ptr (
    .clk (clk),
    .rst (rst),
    .op  (op),
    .ptr (ptr)
  );

  crs_store #(.N(STK_DEPTH), .W(STK_W), .A_W(P_W)) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (push_addr),
    .raddr (raddr),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tos <= '0;
    end else begin
      unique case (op)
        OP_PUSH, OP_SWAP: tos <= push_addr;
        OP_POP:           tos <= rdata;
        default:          tos <= tos;
      endcase
    end
  end

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
    push |=> tos == $past(push_addr)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop) |=> $stable(tos)); // R8
endmodule

// File: tb/circ_ret_stack_tb_top.sv
module circ_ret_stack_tb_top;
  localparam int W = 13;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         push = 1'b0;
  logic         pop = 1'b0;
  logic [W-1:0] push_addr = '0;
  logic [W-1:0] tos;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [W-1:0] mdl [D];
  int           mptr = 0;
  logic [W-1:0] mtos = '0;

  logic [W-1:0] exp_q [$];
  string        tag_q [$];

  always #5 clk = ~clk;

  circ_ret_stack dut_i (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_addr(push_addr), .tos(tos)
  );

  // Driver: one operation per cycle, expectation queued from the model.
  task automatic op(input bit pu, input bit po, input logic [W-1:0] d, input string tag);
    @(negedge clk);
    push = pu; pop = po; push_addr = d;
    if (po) mptr = (mptr + D - 1) % D;
    if (pu) begin
      mdl[mptr] = d;
      mptr = (mptr + 1) % D;
    end
    if (pu) mtos = d;
    else if (po) mtos = mdl[(mptr + D - 1) % D];
    exp_q.push_back(mtos);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (tos !== e) begin
          bad++;
          $display("FAIL %s: tos=%h expected=%h", t, tos, e);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #2;
        total++;
        if (tos !== '0) begin bad++; $display("FAIL R1: tos=%h expected=0", tos); end
        @(negedge clk); rst = 1'b0;
        op(0, 0, '0, "R1 idle after reset");
        // R2/R3/R4: fill all eight, then unwind
        for (int i = 0; i < D; i++) op(1, 0, W'(13'h100 + i), "R2 push");
        for (int i = 0; i < D; i++) op(0, 1, '0, "R4 reverse pop");
        // R8: idle holds
        op(0, 0, 13'h1fff, "R8 idle");
        op(0, 0, 13'h0aaa, "R8 idle");
        // R5: ten pushes wrap
        for (int i = 0; i < 10; i++) op(1, 0, W'(13'h0a00 + i), "R5 wrap push");
        for (int i = 0; i < 7; i++) op(0, 1, '0, "R5 pop after wrap");
        // R6: pop past live data returns wrapped stale entry
        op(0, 1, '0, "R6 stale pop");
        op(0, 1, '0, "R6 stale pop");
        // R7: push and pop together replace top
        op(1, 0, 13'h1111, "R3 setup");
        op(1, 0, 13'h1222, "R3 setup");
        op(1, 1, 13'h1333, "R7 swap");
        op(0, 0, '0, "R7 hold");
        op(0, 1, '0, "R7 below intact");
        op(0, 1, '0, "R3 pop");
        op(0, 0, '0, "R8 drain");
        @(negedge clk); push = 0; pop = 0;
        repeat (3) @(posedge clk);
        #3;
        done = 1;
      end
      begin
        repeat (2000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog: timeout expected=done");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule